// File: doc/BRIEF.md
# Multi-Address I2C Slave Address Matcher

This block watches an I2C bus (SCL and SDA, already filtered) and decodes the first byte after every START or repeated START. It compares the seven address bits with several candidate addresses at once. The first is the device address set by seven strap inputs. The second is a broadcast address that is enabled at reset. Three more are programmable alias addresses. The last is a fixed software-reset call byte. When one of the enabled candidates matches, the block pulls SDA low during the ninth clock. It also reports which class of address won and the read/write bit. A reset call also raises a one-cycle strobe when its acknowledge clock ends.

The alias addresses and their enable bits come in on configuration inputs. The block holds its own working copy of them, and that copy starts at the reset defaults. It takes new configuration values either at a STOP or at the end of each acknowledge the block gives; an input selects which. The register file that drives these inputs and the data-phase protocol belong to other blocks.

Top module: `i2cAddrMatcher`

## Requirements
- R1: After reset `sdaPullLow`=0, `matched`=0, `matchType`=0 and `resetCallPulse`=0.
- R2: An address byte whose upper seven bits equal `hwAddr` is acknowledged. `sdaPullLow` holds SDA low for the whole ninth SCL high phase, and `matchType`=2.
- R3: A byte that matches nothing is not acknowledged, and `matched` stays 0. All later bits are ignored until the next START, even if they form a valid address.
- R4: The broadcast address starts at 1110000 and is enabled at reset. A match reports `matchType`=3.
- R5: The three alias addresses are disabled at reset, with default values 1110001, 1110010 and 1110100. An enabled alias i (0..2) that matches reports `matchType`=4+i.
- R6: The byte 0x06 (address 0000011, write) is always recognised and reports `matchType`=1. It raises `resetCallPulse` for exactly one clock after its acknowledge clock. Byte 0x07 is not a reset call.
- R7: When several candidates match, the reported code follows this order: reset call, then strap address, then broadcast, then alias 0, 1 and 2.
- R8: With `applyOnAck`=0, changes on the configuration inputs take effect only at the next STOP.
- R9: With `applyOnAck`=1, configuration inputs are taken at the end of each acknowledge clock, so a later repeated START in the same transfer already uses them.
- R10: A repeated START restarts address matching without a STOP.
- R11: A STOP or START clears `matched` and sets `matchType` to 0.
- R12: `rnw` gives bit 0 of an acknowledged address byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | system clock |
| rstN | input | 1 | active-low asynchronous reset |
| sclIn | input | 1 | filtered SCL level |
| sdaIn | input | 1 | filtered SDA level |
| hwAddr | input | 7 | strap address |
| allCallAddrIn | input | 7 | broadcast address from configuration |
| allCallEnIn | input | 1 | broadcast address enable |
| subAddrIn | input | 21 | alias addresses, alias i in bits 7i+6..7i |
| subEnIn | input | 3 | alias enables, bit i for alias i |
| applyOnAck | input | 1 | 1: take configuration at acknowledge end; 0: at STOP |
| sdaPullLow | output | 1 | drive SDA low (acknowledge) |
| matched | output | 1 | current transfer is addressed to this device |
| matchType | output | 3 | 0 none, 1 reset call, 2 strap, 3 broadcast, 4..6 alias |
| rnw | output | 1 | read/write bit of the acknowledged address |
| resetCallPulse | output | 1 | one-cycle strobe after a reset-call acknowledge |

## Verification
A bit counter that has drifted by one shifts the sampled byte. The block then acknowledges the wrong addresses or pulls SDA in the eighth or tenth clock, and this shows in the first address byte after the fault. A stale working copy of the configuration shows as a missing or extra acknowledge on the first transfer after a STOP or after an acknowledge. A wrong priority shows only when two candidates are equal, so the bench makes them equal on purpose.

// File: rtl/i2cAddrMatchPkg.sv
package i2cAddrMatchPkg;
  localparam int ADDR_W    = 7;
  localparam int BYTE_BITS = ADDR_W + 1;
  localparam int CODE_W    = 3;

  localparam logic [ADDR_W-1:0] ALL_CALL_DEFAULT = 7'b1110000;
  localparam logic [7:0]        RESET_CALL_BYTE  = 8'h06;

  localparam logic [CODE_W-1:0] CODE_NONE     = 3'd0;
  localparam logic [CODE_W-1:0] CODE_RESET    = 3'd1;
  localparam logic [CODE_W-1:0] CODE_HW       = 3'd2;
  localparam logic [CODE_W-1:0] CODE_ALL      = 3'd3;
  localparam logic [CODE_W-1:0] CODE_SUB_BASE = 3'd4;

  // strobes from bus control to the address datapath
  typedef struct packed {
    logic startDet;
    logic stopDet;
    logic shiftEn;
    logic evalEn;
    logic ackDone;
  } busStrobe_t;

  // alias default: broadcast pattern with one extra low bit set
  function automatic logic [ADDR_W-1:0] subDefault(input int idx);
    return ALL_CALL_DEFAULT | (ADDR_W'(1) << idx);
  endfunction
endpackage

// File: rtl/i2cAddrCtrl.sv
module i2cAddrCtrl
  import i2cAddrMatchPkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       sclIn,
  input  logic       sdaIn,
  input  logic       hitAny,
  output busStrobe_t strobe,
  output logic       sdaBit,
  output logic       pullLow
);
  localparam int CNT_W = $clog2(BYTE_BITS + 1);

  typedef enum logic [2:0] {ST_IDLE, ST_ADDR, ST_ACK, ST_HOLD, ST_SKIP} state_t;

  logic [1:0] sclSync, sdaSync;
  logic       sclPrev, sdaPrev;
  logic       sclNow, sdaNow, sclRise, sclFall;
  state_t     state, stateNext;
  logic [CNT_W-1:0] bitCnt, bitCntNext;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclSync <= '1;
      sdaSync <= '1;
      sclPrev <= 1'b1;
      sdaPrev <= 1'b1;
    end else begin
      sclSync <= {sclSync[0], sclIn};
      sdaSync <= {sdaSync[0], sdaIn};
      sclPrev <= sclSync[1];
      sdaPrev <= sdaSync[1];
    end
  end

  assign sclNow  = sclSync[1];
  assign sdaNow  = sdaSync[1];
  assign sclRise = sclNow & ~sclPrev;
  assign sclFall = ~sclNow & sclPrev;
  assign sdaBit  = sdaNow;

  always_comb begin
    strobe          = '0;
    strobe.startDet = sclNow & sclPrev & sdaPrev & ~sdaNow;
    strobe.stopDet  = sclNow & sclPrev & ~sdaPrev & sdaNow;
    strobe.shiftEn  = (state == ST_ADDR) && sclRise && (bitCnt < CNT_W'(BYTE_BITS));
    strobe.evalEn   = (state == ST_ADDR) && sclFall && (bitCnt == CNT_W'(BYTE_BITS));
    strobe.ackDone  = (state == ST_ACK) && sclFall;
  end

  always_comb begin
    stateNext  = state;
    bitCntNext = bitCnt;
    if (strobe.startDet) begin
      stateNext  = ST_ADDR;
      bitCntNext = '0;
    end else if (strobe.stopDet) begin
      stateNext  = ST_IDLE;
      bitCntNext = '0;
    end else begin
      unique case (state)
        ST_ADDR: begin
          if (strobe.shiftEn) bitCntNext = bitCnt + 1'b1;
          if (strobe.evalEn)  stateNext  = hitAny ? ST_ACK : ST_SKIP;
        end
        ST_ACK:  if (strobe.ackDone) stateNext = ST_HOLD;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state  <= ST_IDLE;
      bitCnt <= '0;
    end else begin
      state  <= stateNext;
      bitCnt <= bitCntNext;
    end
  end

  assign pullLow = (state == ST_ACK);
endmodule

// File: rtl/i2cAddrData.sv
module i2cAddrData
  import i2cAddrMatchPkg::*;
#(
  parameter int NUM_SUB = 3
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  busStrobe_t                strobe,
  input  logic                      sdaBit,
  input  logic [ADDR_W-1:0]         hwAddr,
  input  logic [ADDR_W-1:0]         allCallAddrIn,
  input  logic                      allCallEnIn,
  input  logic [NUM_SUB*ADDR_W-1:0] subAddrIn,
  input  logic [NUM_SUB-1:0]        subEnIn,
  input  logic                      applyOnAck,
  output logic                      hitAny,
  output logic                      matched,
  output logic [CODE_W-1:0]         matchType,
  output logic                      rnw,
  output logic                      resetCallPulse
);
  logic [BYTE_BITS-1:0] shiftReg;
  logic [ADDR_W-1:0]    rxAddr;
  logic                 loadCfg;
  logic [ADDR_W-1:0]    activeAll;
  logic                 activeAllEn;
  logic [NUM_SUB-1:0]   activeSubEn;
  logic [NUM_SUB-1:0]   subHit;
  logic                 rstHit, hwHit, allHit;
  logic [CODE_W-1:0]    hitCode;

  assign rxAddr  = shiftReg[BYTE_BITS-1:1];
  assign loadCfg = applyOnAck ? strobe.ackDone : strobe.stopDet;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)               shiftReg <= '0;
    else if (strobe.shiftEn) shiftReg <= {shiftReg[BYTE_BITS-2:0], sdaBit};
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      activeAll   <= ALL_CALL_DEFAULT;
      activeAllEn <= 1'b1;
      activeSubEn <= '0;
    end else if (loadCfg) begin
      activeAll   <= allCallAddrIn;
      activeAllEn <= allCallEnIn;
      activeSubEn <= subEnIn;
    end
  end

  for (genvar g = 0; g < NUM_SUB; g++) begin : genSub
    logic [ADDR_W-1:0] activeSub;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)        activeSub <= subDefault(g);
      else if (loadCfg) activeSub <= subAddrIn[g*ADDR_W +: ADDR_W];
    end
    assign subHit[g] = activeSubEn[g] && (activeSub == rxAddr);
  end

  assign rstHit = (shiftReg == RESET_CALL_BYTE);
  assign hwHit  = (rxAddr == hwAddr);
  assign allHit = activeAllEn && (activeAll == rxAddr);

  // lowest-priority candidates assigned first, overwritten by higher ones
  always_comb begin
    hitCode = CODE_NONE;
    for (int i = NUM_SUB - 1; i >= 0; i--) begin
      if (subHit[i]) hitCode = CODE_SUB_BASE + CODE_W'(i);
    end
    if (allHit) hitCode = CODE_ALL;
    if (hwHit)  hitCode = CODE_HW;
    if (rstHit) hitCode = CODE_RESET;
  end

  assign hitAny = (hitCode != CODE_NONE);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      matched        <= 1'b0;
      matchType      <= CODE_NONE;
      rnw            <= 1'b0;
      resetCallPulse <= 1'b0;
    end else begin
      resetCallPulse <= strobe.ackDone && (matchType == CODE_RESET);
      if (strobe.startDet || strobe.stopDet) begin
        matched   <= 1'b0;
        matchType <= CODE_NONE;
        rnw       <= 1'b0;
      end else if (strobe.evalEn) begin
        matched   <= hitAny;
        matchType <= hitCode;
        rnw       <= hitAny & shiftReg[0];
      end
    end
  end
endmodule

// File: rtl/i2cAddrMatcher.sv
module i2cAddrMatcher
  import i2cAddrMatchPkg::*;
#(
  parameter int NUM_SUB = 3
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic                      sclIn,
  input  logic                      sdaIn,
  input  logic [ADDR_W-1:0]         hwAddr,
  input  logic [ADDR_W-1:0]         allCallAddrIn,
  input  logic                      allCallEnIn,
  input  logic [NUM_SUB*ADDR_W-1:0] subAddrIn,
  input  logic [NUM_SUB-1:0]        subEnIn,
  input  logic                      applyOnAck,
  output logic                      sdaPullLow,
  output logic                      matched,
  output logic [CODE_W-1:0]         matchType,
  output logic                      rnw,
  output logic                      resetCallPulse
);
  busStrobe_t strobe;
  logic       sdaBit;
  logic       hitAny;

  i2cAddrCtrl ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .sclIn   (sclIn),
    .sdaIn   (sdaIn),
    .hitAny  (hitAny),
    .strobe  (strobe),
    .sdaBit  (sdaBit),
    .pullLow (sdaPullLow)
  );

  i2cAddrData #(.NUM_SUB(NUM_SUB)) data (
    .clk            (clk),
    .rstN           (rstN),
    .strobe         (strobe),
    .sdaBit         (sdaBit),
    .hwAddr         (hwAddr),
    .allCallAddrIn  (allCallAddrIn),
    .allCallEnIn    (allCallEnIn),
    .subAddrIn      (subAddrIn),
    .subEnIn        (subEnIn),
    .applyOnAck     (applyOnAck),
    .hitAny         (hitAny),
    .matched        (matched),
    .matchType      (matchType),
    .rnw            (rnw),
    .resetCallPulse (resetCallPulse)
  );
endmodule

// File: rtl/i2cAddrMatcherChecker.sv
module i2cAddrMatcherChecker
  import i2cAddrMatchPkg::*;
(
  input logic              clk,
  input logic              rstN,
  input logic              sdaPullLow,
  input logic              matched,
  input logic [CODE_W-1:0] matchType,
  input logic              rnw,
  input logic              resetCallPulse
);
  assert_ack_needs_match_R2: assert property (@(posedge clk) disable iff (!rstN)
    sdaPullLow |-> matched);

  assert_idle_code_none_R11: assert property (@(posedge clk) disable iff (!rstN)
    !matched |-> (matchType == CODE_NONE) && !rnw);

  assert_reset_pulse_type_R6: assert property (@(posedge clk) disable iff (!rstN)
    resetCallPulse |-> (matchType == CODE_RESET) && !rnw);

  assert_reset_pulse_single_R6: assert property (@(posedge clk) disable iff (!rstN)
    resetCallPulse |=> !resetCallPulse);

  assert_code_range_R7: assert property (@(posedge clk) disable iff (!rstN)
    matchType <= CODE_SUB_BASE + 3'd2);

  assert_no_pull_with_pulse_R6: assert property (@(posedge clk) disable iff (!rstN)
    resetCallPulse |-> !sdaPullLow);
endmodule

bind i2cAddrMatcher i2cAddrMatcherChecker chk (
  .clk            (clk),
  .rstN           (rstN),
  .sdaPullLow     (sdaPullLow),
  .matched        (matched),
  .matchType      (matchType),
  .rnw            (rnw),
  .resetCallPulse (resetCallPulse)
);

// File: tb/i2cAddrMatcher_test.sv
module i2cAddrMatcher_test;
  localparam int QTR = 8;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        sclDrv = 1'b1, sdaDrv = 1'b1;
  logic        sdaBus;
  logic [6:0]  hwAddr = 7'h2A;
  logic [6:0]  allCallAddrIn = 7'b1110000;
  logic        allCallEnIn = 1'b1;
  logic [20:0] subAddrIn = '0;
  logic [2:0]  subEnIn = '0;
  logic        applyOnAck = 1'b0;
  logic        sdaPullLow, matched, rnw, resetCallPulse;
  logic [2:0]  matchType;

  int total = 0, bad = 0, pulses = 0;
  bit done = 0;

  always #4 clk = ~clk;

  assign sdaBus = sdaDrv & ~sdaPullLow;

  i2cAddrMatcher uut (
    .clk(clk), .rstN(rstN), .sclIn(sclDrv), .sdaIn(sdaBus),
    .hwAddr(hwAddr), .allCallAddrIn(allCallAddrIn), .allCallEnIn(allCallEnIn),
    .subAddrIn(subAddrIn), .subEnIn(subEnIn), .applyOnAck(applyOnAck),
    .sdaPullLow(sdaPullLow), .matched(matched), .matchType(matchType),
    .rnw(rnw), .resetCallPulse(resetCallPulse)
  );

  always @(posedge clk) if (resetCallPulse) pulses++;

  // byte, expected ack, expected code, expected rw
  localparam logic [12:0] VEC [0:7] = '{
    {8'h54, 1'b1, 3'd2, 1'b0},  // R2 strap write
    {8'h55, 1'b1, 3'd2, 1'b1},  // R12 strap read
    {8'hE0, 1'b1, 3'd3, 1'b0},  // R4 broadcast default
    {8'h06, 1'b1, 3'd1, 1'b0},  // R6 reset call
    {8'h07, 1'b0, 3'd0, 1'b0},  // R6 read variant refused
    {8'hE2, 1'b0, 3'd0, 1'b0},  // R5 alias 0 disabled at reset
    {8'h5A, 1'b0, 3'd0, 1'b0},  // R3 unrelated
    {8'h00, 1'b0, 3'd0, 1'b0}   // R3 unrelated
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic phase();
    repeat (QTR) @(negedge clk);
  endtask

  task automatic busStart();
    sdaDrv = 1'b1; phase();
    sclDrv = 1'b1; phase();
    sdaDrv = 1'b0; phase();
    sclDrv = 1'b0; phase();
  endtask

  task automatic busStop();
    sdaDrv = 1'b0; phase();
    sclDrv = 1'b1; phase();
    sdaDrv = 1'b1; phase(); phase();
  endtask

  task automatic sendByte(input logic [7:0] b);
    for (int i = 7; i >= 0; i--) begin
      sdaDrv = b[i]; phase();
      sclDrv = 1'b1; phase(); phase();
      sclDrv = 1'b0; phase();
    end
  endtask

  task automatic ackClock(output logic gotAck, output logic [2:0] typ, output logic rw);
    sdaDrv = 1'b1; phase();
    sclDrv = 1'b1; phase();
    gotAck = ~sdaBus;
    typ    = matchType;
    rw     = rnw;
    phase();
    sclDrv = 1'b0; phase();
  endtask

  task automatic addrCycle(input logic [7:0] b, input logic expAck,
                           input logic [2:0] expType, input string req);
    logic a; logic [2:0] t; logic r;
    sendByte(b);
    ackClock(a, t, r);
    check({req, " ack"}, a, expAck);
    check({req, " type"}, t, expType);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 pull", sdaPullLow, 0);
    check("R1 matched", matched, 0);
    check("R1 type", matchType, 0);
    check("R1 pulse", resetCallPulse, 0);
    rstN = 1'b1;
    phase();

    for (int v = 0; v < 8; v++) begin
      logic a; logic [2:0] t; logic r;
      busStart();
      sendByte(VEC[v][12:5]);
      ackClock(a, t, r);
      check($sformatf("vec%0d R2/R3/R4/R5/R6 ack", v), a, VEC[v][4]);
      check($sformatf("vec%0d R7 type", v), t, VEC[v][3:1]);
      if (VEC[v][4]) check($sformatf("vec%0d R12 rnw", v), r, VEC[v][0]);
      busStop();
      check("R11 cleared after stop", {matched, matchType}, 0);
    end
    check("R6 one pulse after table", pulses, 1);

    // R8: alias config not used until STOP, then R5 alias codes
    subAddrIn = {7'h13, 7'h12, 7'h11};
    subEnIn   = 3'b111;
    busStart(); addrCycle(8'h22, 0, 0, "R8 before stop"); busStop();
    busStart(); addrCycle(8'h22, 1, 4, "R5 alias0"); busStop();
    busStart(); addrCycle(8'h24, 1, 5, "R5 alias1"); busStop();
    busStart(); addrCycle(8'h26, 1, 6, "R5 alias2"); busStop();

    // R7 priority with equal candidates
    allCallAddrIn = 7'h2A;
    subAddrIn[6:0] = 7'h2A;
    busStart(); busStop();
    busStart(); addrCycle(8'h54, 1, 2, "R7 strap over broadcast"); busStop();
    hwAddr = 7'h3C;
    busStart(); addrCycle(8'h54, 1, 3, "R7 broadcast over alias"); busStop();
    allCallEnIn = 1'b0;
    busStart(); busStop();
    busStart(); addrCycle(8'h54, 1, 4, "R7 alias0 alone"); busStop();
    hwAddr = 7'h03;
    busStart(); addrCycle(8'h06, 1, 1, "R7 reset over strap"); busStop();
    check("R6 second pulse", pulses, 2);

    hwAddr = 7'h2A; allCallAddrIn = 7'b1110000; allCallEnIn = 1'b1;
    subAddrIn[6:0] = 7'h11;
    busStart(); busStop();

    // R3: after a refused byte, a valid address without START is ignored
    busStart();
    addrCycle(8'hAA, 0, 0, "R3 refused");
    addrCycle(8'h54, 0, 0, "R3 ignored without start");
    busStop();

    // R10: repeated START restarts matching
    busStart();
    addrCycle(8'hAA, 0, 0, "R10 first refused");
    busStart();
    addrCycle(8'h54, 1, 2, "R10 after repeated start");
    busStop();

    // R9: configuration taken at acknowledge end
    applyOnAck = 1'b1;
    allCallAddrIn = 7'h33;
    busStart();
    addrCycle(8'h54, 1, 2, "R9 strap");
    busStart();
    addrCycle(8'h66, 1, 3, "R9 new broadcast");
    busStart();
    addrCycle(8'hE0, 0, 0, "R9 old broadcast gone");
    busStop();
    check("R11 matched after stop", matched, 0);
    check("R11 type after stop", matchType, 0);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule